// File: doc/BRIEF.md
# Byte-Laned Static RAM Model

This block is a clocked, synthesizable stand-in for a 16-bit-wide static RAM that is normally driven by asynchronous control pins. Two chip selects of opposite polarity, a write strobe, an output-enable strobe and two byte-lane strobes are all sampled on the rising edge of an internal clock. Every edge, the block sorts those pins into one of four modes: idle, read with outputs held off, read, or write. Writes store only the enabled bytes of the word.

The data path uses separate buses in each direction. Tristate pads are replaced by one enable output per byte lane. A system model or an FPGA prototype can use the block where the real memory part would sit. The enables show which half of `rd_data` would be driving the shared bus. The bits of a lane that is off are forced to zero, so the output is always a known value.

The storage depth is `2**ADDR_W` words. `ADDR_W = 17` gives the full 128K x 16 organization. The default is smaller to keep elaboration light.

Top module: `sram_lane_model`

## Requirements
- R1: The block stores `2**ADDR_W` words of 16 bits. A word written at an address is returned by a later read of that same address.
- R2: The block is deselected when `sel_n` is 1, or `sel_hi` is 0, or both `lo_n` and `hi_n` are 1. While deselected, both `oe_lo` and `oe_hi` are 0 and no byte of the memory changes.
- R3: Write mode is `sel_n`=0, `sel_hi`=1, `wr_n`=0, with at least one lane strobe at 0. In write mode both lane enables are 0, whatever the value of `out_en_n`.
- R4: In write mode, `lo_n`=0 stores `wr_data[7:0]` in bits [7:0] of the addressed word, and `hi_n`=0 stores `wr_data[15:8]` in bits [15:8]. A byte whose strobe is 1 keeps its previous contents.
- R5: Read mode is selected with `wr_n`=1. With `out_en_n`=0 in read mode:
  - `oe_lo`=1 when `lo_n`=0, and `rd_data[7:0]` then carries stored bits [7:0];
  - `oe_hi`=1 when `hi_n`=0, and `rd_data[15:8]` then carries stored bits [15:8].
- R6: In read mode with `out_en_n`=1, both lane enables are 0.
- R7: In read mode, a lane whose strobe is 1 stays disabled while the other lane drives.
- R8: All inputs are sampled on the rising clock edge.
  - A write commits on the edge where the write is sampled.
  - Lane enables and read data reflect the inputs sampled at the previous edge.
  - A read sampled on the edge right after a write to the same address returns the new bytes.
- R9: Bits of `rd_data` that belong to a disabled lane are 0.
- R10: While `rst` is 1, both lane enables are 0 one edge later. Reset does not alter the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and write clock |
| rst | input | 1 | Synchronous active-high reset of the output enables |
| sel_n | input | 1 | Active-low chip select |
| sel_hi | input | 1 | Active-high chip select |
| wr_n | input | 1 | Active-low write strobe |
| out_en_n | input | 1 | Active-low output enable |
| lo_n | input | 1 | Active-low strobe for bits [7:0] |
| hi_n | input | 1 | Active-low strobe for bits [15:8] |
| addr | input | ADDR_W | Word address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, zero in disabled lanes |
| oe_lo | output | 1 | Lane enable for bits [7:0] |
| oe_hi | output | 1 | Lane enable for bits [15:8] |

## Verification
The bench first goes after the ways a decoder can leak. These cases are:
- a write sampled with `out_en_n` low, which a naive design would answer by turning a lane on;
- `sel_hi` dropped in the middle of a write sequence, which a design that checks only `sel_n` would still commit to memory;
- both strobes high, where a selected-looking cycle must act as a deselect.

Byte masking is attacked next. A single-byte write is followed by a word read, so a design that writes the whole word, or swaps the lanes, returns a corrupted neighbour byte. The bench also reads immediately after a write, to catch an off-by-one latency. It pulses reset between writes and reads, to catch a reset that clears the array or leaves an enable set.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned WORD_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_HIDDEN = 2'd1,
    MODE_READ   = 2'd2,
    MODE_WRITE  = 2'd3
  } sram_mode_e;

  typedef struct packed {
    logic sel_n;
    logic sel_hi;
    logic wr_n;
    logic out_en_n;
    logic hi_n;
    logic lo_n;
  } sram_ctl_t;

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import sram_lane_pkg::*;
(
  input  sram_ctl_t        ctl,
  output sram_mode_e       mode,
  output logic [LANES-1:0] lane_req
);

  logic chip_on;

  // lane_req[0] = low byte, lane_req[1] = high byte
  assign lane_req = {~ctl.hi_n, ~ctl.lo_n};
  assign chip_on  = ~ctl.sel_n & ctl.sel_hi & (|lane_req);

  always_comb begin
    if (!chip_on)          mode = MODE_IDLE;
    else if (!ctl.wr_n)    mode = MODE_WRITE;
    else if (ctl.out_en_n) mode = MODE_HIDDEN;
    else                   mode = MODE_READ;
  end

endmodule

// File: rtl/sram_byte_bank.sv
module sram_byte_bank #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read-first single-port array: maps onto one block RAM port
  always_ff @(posedge clk) begin
    if (wen) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_lane_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  sram_mode_e            mode,
  input  logic [LANES-1:0]      lane_req,
  input  logic [WORD_W-1:0]     bank_q,
  output logic [LANES-1:0]      lane_oe,
  output logic [WORD_W-1:0]     word_out
);

  always_ff @(posedge clk) begin
    if (rst) lane_oe <= '0;
    else     lane_oe <= (mode == MODE_READ) ? lane_req : '0;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign word_out[g*LANE_W +: LANE_W] =
      lane_oe[g] ? bank_q[g*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/sram_lane_model.sv
module sram_lane_model
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              wr_n,
  input  logic              out_en_n,
  input  logic              lo_n,
  input  logic              hi_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  output logic              oe_lo,
  output logic              oe_hi
);

  sram_ctl_t         ctl;
  sram_mode_e        mode;
  logic [LANES-1:0]  lane_req;
  logic [LANES-1:0]  lane_oe;
  logic [WORD_W-1:0] bank_q;

  assign ctl = '{sel_n: sel_n, sel_hi: sel_hi, wr_n: wr_n,
                 out_en_n: out_en_n, hi_n: hi_n, lo_n: lo_n};

  sram_mode_decode u_dec (
    .ctl      (ctl),
    .mode     (mode),
    .lane_req (lane_req)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_byte_bank #(.ADDR_W(ADDR_W), .DATA_W(LANE_W)) u_bank (
      .clk   (clk),
      .wen   ((mode == MODE_WRITE) && lane_req[g]),
      .addr  (addr),
      .wdata (wr_data[g*LANE_W +: LANE_W]),
      .rdata (bank_q[g*LANE_W +: LANE_W])
    );
  end

  sram_out_stage u_out (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .lane_req (lane_req),
    .bank_q   (bank_q),
    .lane_oe  (lane_oe),
    .word_out (rd_data)
  );

  assign oe_lo = lane_oe[0];
  assign oe_hi = lane_oe[1];

endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk (
  input logic        clk,
  input logic        rst,
  input logic        sel_n,
  input logic        sel_hi,
  input logic        wr_n,
  input logic        out_en_n,
  input logic        lo_n,
  input logic        hi_n,
  input logic [15:0] rd_data,
  input logic        oe_lo,
  input logic        oe_hi
);

  logic pin_sel;
  assign pin_sel = !sel_n && sel_hi && !(lo_n && hi_n);

  p_deselect_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !pin_sel |=> (!oe_lo && !oe_hi));

  p_write_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (pin_sel && !wr_n) |=> (!oe_lo && !oe_hi));

  p_read_lo_drives_r5: assert property (@(posedge clk) disable iff (rst)
    (pin_sel && wr_n && !out_en_n && !lo_n) |=> oe_lo);

  p_read_hi_drives_r5: assert property (@(posedge clk) disable iff (rst)
    (pin_sel && wr_n && !out_en_n && !hi_n) |=> oe_hi);

  p_hidden_read_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (pin_sel && wr_n && out_en_n) |=> (!oe_lo && !oe_hi));

  p_lo_gated_r7: assert property (@(posedge clk) disable iff (rst)
    (pin_sel && wr_n && lo_n) |=> !oe_lo);

  p_hi_gated_r7: assert property (@(posedge clk) disable iff (rst)
    (pin_sel && wr_n && hi_n) |=> !oe_hi);

  p_dead_lanes_zero_r9: assert property (@(posedge clk) disable iff (rst)
    ((!oe_lo -> rd_data[7:0] == 8'h00) && (!oe_hi -> rd_data[15:8] == 8'h00)));

  p_reset_quiet_r10: assert property (@(posedge clk)
    rst |=> (!oe_lo && !oe_hi));

endmodule

bind sram_lane_model sram_lane_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .sel_n    (sel_n),
  .sel_hi   (sel_hi),
  .wr_n     (wr_n),
  .out_en_n (out_en_n),
  .lo_n     (lo_n),
  .hi_n     (hi_n),
  .rd_data  (rd_data),
  .oe_lo    (oe_lo),
  .oe_hi    (oe_hi)
);

// File: tb/sram_lane_model_tb_top.sv
`timescale 1ns/1ps
module sram_lane_model_tb_top;

  localparam int unsigned AW    = 11;
  localparam int unsigned DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_n = 1'b1, sel_hi = 1'b0, wr_n = 1'b1, out_en_n = 1'b1;
  logic          lo_n = 1'b1, hi_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wr_data = '0;
  logic [15:0]   rd_data;
  logic          oe_lo, oe_hi;

  logic [15:0]   ref_mem [DEPTH];
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  sram_lane_model #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sel_hi(sel_hi), .wr_n(wr_n),
    .out_en_n(out_en_n), .lo_n(lo_n), .hi_n(hi_n), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .oe_lo(oe_lo), .oe_hi(oe_hi)
  );

  // Expected {oe_lo, oe_hi, rd_data} from the requirements
  function automatic logic [17:0] expect_out(
      input logic c1n, c2, wn, on, ln, hn, input logic [15:0] word);
    logic sel, rd, elo, ehi;
    sel = !c1n && c2 && !(ln && hn);
    rd  = sel && wn && !on;
    elo = rd && !ln;
    ehi = rd && !hn;
    return {elo, ehi, (ehi ? word[15:8] : 8'h00), (elo ? word[7:0] : 8'h00)};
  endfunction

  function automatic logic [15:0] merge_word(
      input logic [15:0] old, input logic [15:0] d, input logic ln, hn);
    return {(hn ? old[15:8] : d[15:8]), (ln ? old[7:0] : d[7:0])};
  endfunction

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got oe_lo/oe_hi/data=%b/%b/%h expected %b/%b/%h",
               req, act[17], act[16], act[15:0], exp[17], exp[16], exp[15:0]);
    end
  endtask

  // One bus cycle: drive at negedge, sampled at posedge, checked 2 ns later
  task automatic op(input logic c1n, c2, wn, on, ln, hn,
                    input logic [AW-1:0] a, input logic [15:0] d, input string req);
    logic [17:0] exp;
    logic        sel;
    @(negedge clk);
    sel_n = c1n; sel_hi = c2; wr_n = wn; out_en_n = on;
    lo_n = ln; hi_n = hn; addr = a; wr_data = d;
    @(posedge clk);
    #2;
    exp = expect_out(c1n, c2, wn, on, ln, hn, ref_mem[a]);
    check(req, {oe_lo, oe_hi, rd_data}, exp);
    sel = !c1n && c2 && !(ln && hn);
    if (sel && !wn) ref_mem[a] = merge_word(ref_mem[a], d, ln, hn);
  endtask

  function automatic string pick_tag(input logic c1n, c2, wn, on, ln, hn);
    if (c1n || !c2 || (ln && hn)) return "R2";
    if (!wn)                      return "R3";
    if (on)                       return "R6";
    if (ln || hn)                 return "R7";
    return "R5";
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8: watchdog expired, got hung run expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_1234));
    // R10: enables off during reset
    repeat (3) @(posedge clk);
    #2;
    check("R10", {oe_lo, oe_hi, rd_data}, 18'h0);
    @(negedge clk) rst = 1'b0;

    // R1: fill every word with a full-word write
    for (int i = 0; i < DEPTH; i++) begin
      logic [15:0] v;
      v = 16'(i * 16'h9E37) ^ 16'h5A5A;
      op(0, 1, 0, 1, 0, 0, AW'(i), v, "R1");
    end
    op(0, 1, 1, 0, 0, 0, AW'(5), 16'h0, "R1");

    // R3: write with out_en_n low keeps lanes off
    op(0, 1, 0, 0, 0, 0, AW'(7), 16'hBEEF, "R3");
    // R8: read right after write sees the new word
    op(0, 1, 1, 0, 0, 0, AW'(7), 16'h0, "R8");

    // R4: low-byte-only write then word read
    op(0, 1, 0, 1, 0, 1, AW'(9), 16'h1234, "R4");
    op(0, 1, 1, 0, 0, 0, AW'(9), 16'h0, "R4");
    // R4: high-byte-only write then word read
    op(0, 1, 0, 0, 1, 0, AW'(9), 16'hABCD, "R4");
    op(0, 1, 1, 0, 0, 0, AW'(9), 16'h0, "R4");

    // R2: sel_hi dropped mid sequence, write must not land
    op(0, 1, 0, 1, 0, 0, AW'(11), 16'h1111, "R2");
    op(0, 0, 0, 1, 0, 0, AW'(11), 16'h2222, "R2");
    op(0, 1, 1, 0, 0, 0, AW'(11), 16'h0, "R2");
    // R2: both strobes high acts as deselect, no write
    op(0, 1, 0, 0, 1, 1, AW'(11), 16'h3333, "R2");
    op(0, 1, 1, 0, 0, 0, AW'(11), 16'h0, "R2");
    // R2: sel_n high
    op(1, 1, 1, 0, 0, 0, AW'(11), 16'h0, "R2");

    // R6: hidden read
    op(0, 1, 1, 1, 0, 0, AW'(11), 16'h0, "R6");
    // R7 / R9: single-lane reads
    op(0, 1, 1, 0, 0, 1, AW'(9), 16'h0, "R7");
    op(0, 1, 1, 0, 1, 0, AW'(9), 16'h0, "R9");

    // R10: reset mid-run leaves memory intact
    @(negedge clk);
    rst = 1'b1; sel_n = 0; sel_hi = 1; wr_n = 1; out_en_n = 0; lo_n = 0; hi_n = 0;
    @(posedge clk);
    #2;
    check("R10", {oe_lo, oe_hi, rd_data}, 18'h0);
    @(negedge clk) rst = 1'b0;
    op(0, 1, 1, 0, 0, 0, AW'(9), 16'h0, "R10");
    op(0, 1, 1, 0, 0, 0, AW'(11), 16'h0, "R10");

    // Constrained random mix, biased toward a selected chip
    for (int n = 0; n < 4000; n++) begin
      logic c1n, c2, wn, on, ln, hn;
      logic [AW-1:0] a;
      logic [15:0]   d;
      c1n = ($urandom_range(0, 7) == 0);
      c2  = ($urandom_range(0, 7) != 0);
      wn  = ($urandom_range(0, 2) != 0);
      on  = ($urandom_range(0, 3) == 0);
      ln  = ($urandom_range(0, 2) == 0);
      hn  = ($urandom_range(0, 2) == 0);
      a   = AW'($urandom_range(0, 31));
      d   = 16'($urandom);
      op(c1n, c2, wn, on, ln, hn, a, d, pick_tag(c1n, c2, wn, on, ln, hn));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule